// File: doc/BRIEF.md
# Min-Sum Convolutional Parity Decoder Stage

This block is one stage of a soft-decision decoder for a regular (3,6) rate-1/2 convolutional parity code of memory M. A stream of signed 6-bit log-likelihood ratios comes in, one time step per valid strobe: for the information bit and for the code bit there are three message values and one channel value. Four register delay lines, each M+1 positions deep, carry these values through the stage. On every strobe one check node reads six values at positions picked by the current phase. It computes the sign-minimum update and writes the results back to the positions it read. As a time step leaves the last position, a variable node builds the outgoing messages from the channel value and the messages of that bit. A register chain follows, so that the whole stage has a fixed latency.

Stages are identical and connect in a chain: the output bus of one stage feeds the input bus of the next, and all stages share the phase. The first stage receives channel values on every field. Nothing moves while the valid strobe is low, so stages stay in step through gaps in the stream.

Top module: `ldpc_cc_stage`

## Requirements
- R1: llr_i and llr_o each carry 8 signed 6-bit fields. Field f sits at bits [6f+5:6f] with f = 4*b + l, where b=0 is the information bit, b=1 is the code bit, l=0..2 are the message lines and l=3 is the channel line. While rst_ni is low, llr_o and valid_o are 0 and every delay line is cleared, so a following all-zero stream gives all-zero outputs.
- R2: A channel field (f=3 or f=7) presented with valid strobe k appears unchanged on the same field of llr_o just after the clock edge of strobe k+N, where N = M+1+PIPE_DEPTH (140 with the defaults). It is not there after strobe k+N-1.
- R3: Position j of a line holds the time step taken in j strobes earlier (position 0 holds the previous strobe's input). On a strobe with phase p (0..M-1) the check inputs are: x0 = code bit, line 0, position 0; x1 = code bit, line 1, position 1+((5p+3) mod (M-1)); x2 = code bit, line 2, position M; x3..x5 = information bit, line i (i=0..2), position 1+(((2i+3)p+7i+1) mod (M-1)).
- R4: Check output k has magnitude equal to the smallest of min(|x_n|,31) over the five inputs n other than k. It is negative exactly when an odd number of those five inputs have their sign bit set. A zero magnitude gives the value 0.
- R5: On each strobe the check outputs replace the values at the positions they were read from, and the updated line contents then move one position along.
- R6: The variable node works on the updated position-M contents. The outgoing message on line l of a bit is the channel value plus that bit's two other messages, clamped to [-31,31]. The channel field leaves unchanged. The result then passes through PIPE_DEPTH+1 strobe-enabled registers to llr_o.
- R7: While valid_i is low, llr_i and phase_i have no effect: no line moves and llr_o holds its value.
- R8: valid_o is high in the cycle after each cycle with valid_i high, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Strobe: accept one time step and advance |
| phase_i | input | $clog2(M) | Current phase, 0..M-1, shared by all stages |
| llr_i | input | 48 | Incoming LLR fields (layout in R1) |
| valid_o | output | 1 | High for one cycle after each accepted strobe |
| llr_o | output | 48 | Outgoing LLR fields, same layout |

## Verification
In one strobe the check node rewrites the code-bit value on line 2 at the last position while the variable node reads that same word to form the outgoing messages. So write-back and exit fall in the same cycle, and a wrong order between them changes the output at once. Long random streams, plus runs of all +31 and all -32 values, cause this on every strobe. The bench judges each output word against its own model, which applies the write-back before the exit sum. The saturated runs also drive the clamp and the 31 ceiling on check magnitudes in that cycle.

// File: rtl/ldpc_stage_pkg.sv
package ldpc_stage_pkg;
  localparam int NUM_LINES = 4;   // lines 0..2 messages, line 3 channel
  localparam int NUM_BITS  = 2;   // 0 information, 1 code
  localparam int CHK_DEG   = 6;
  localparam int NUM_INFO  = 3;

  function automatic int code_tap(input int p, input int m);
    return 1 + ((5 * p + 3) % (m - 1));
  endfunction

  function automatic int info_tap(input int i, input int p, input int m);
    return 1 + (((2 * i + 3) * p + 7 * i + 1) % (m - 1));
  endfunction
endpackage

// File: rtl/ldpc_check_node.sv
module ldpc_check_node #(
  parameter int LLR_W = 6,
  parameter int DEG   = 6
) (
  input  logic signed [LLR_W-1:0] x_i [DEG],
  output logic signed [LLR_W-1:0] y_o [DEG]
);
  localparam int MW = LLR_W - 1;
  localparam logic [MW-1:0] MAG_MAX = '1;

  logic [LLR_W-1:0] abs_v [DEG];
  logic [MW-1:0]    mag   [DEG];
  logic [MW-1:0]    sel_mag [DEG];
  logic [MW-1:0]    min1, min2;
  int               min_idx;
  logic             par;

  for (genvar k = 0; k < DEG; k++) begin : g_mag
    assign abs_v[k] = x_i[k][LLR_W-1] ? $unsigned(-x_i[k]) : $unsigned(x_i[k]);
    assign mag[k]   = abs_v[k][LLR_W-1] ? MAG_MAX : abs_v[k][MW-1:0];
  end

  // single pass: smallest, second smallest, position of smallest
  always_comb begin
    min1    = MAG_MAX;
    min2    = MAG_MAX;
    min_idx = 0;
    par     = 1'b0;
    for (int k = 0; k < DEG; k++) begin
      par = par ^ x_i[k][LLR_W-1];
      if (mag[k] < min1) begin
        min2    = min1;
        min1    = mag[k];
        min_idx = k;
      end else if (mag[k] < min2) begin
        min2 = mag[k];
      end
    end
  end

  for (genvar k = 0; k < DEG; k++) begin : g_out
    assign sel_mag[k] = (k == min_idx) ? min2 : min1;
    assign y_o[k] = (par ^ x_i[k][LLR_W-1]) ? -$signed({1'b0, sel_mag[k]})
                                             :  $signed({1'b0, sel_mag[k]});
  end

  logic ysg, ynz;
  always_comb begin
    ysg = 1'b0;
    ynz = 1'b1;
    for (int k = 0; k < DEG; k++) begin
      ysg = ysg ^ y_o[k][LLR_W-1];
      ynz = ynz & (|y_o[k]);
    end
    // with all outputs nonzero, output sign parity equals input sign parity
    if (ynz) begin
      assert_sign_parity_R4: assert (ysg == par)
        else $error("check node sign parity broken");
    end
  end
endmodule

// File: rtl/ldpc_var_node.sv
module ldpc_var_node #(
  parameter int LLR_W = 6
) (
  input  logic signed [LLR_W-1:0] ch_i,
  input  logic signed [LLR_W-1:0] msg_i [3],
  output logic signed [LLR_W-1:0] msg_o [3]
);
  localparam int SW = LLR_W + 2;
  localparam logic signed [SW-1:0] HI = SW'((1 << (LLR_W - 1)) - 1);
  localparam logic signed [SW-1:0] LO = -HI;

  for (genvar k = 0; k < 3; k++) begin : g_sum
    logic signed [SW-1:0] s;
    assign s = SW'(ch_i) + SW'(msg_i[(k + 1) % 3]) + SW'(msg_i[(k + 2) % 3]);
    assign msg_o[k] = (s > HI) ? HI[LLR_W-1:0] :
                      (s < LO) ? LO[LLR_W-1:0] : s[LLR_W-1:0];

    always_comb begin
      assert_vn_clamp_R6: assert (SW'(msg_o[k]) >= LO && SW'(msg_o[k]) <= HI)
        else $error("variable node output outside clamp range");
    end
  end
endmodule

// File: rtl/ldpc_out_pipe.sv
module ldpc_out_pipe #(
  parameter int WIDTH = 48,
  parameter int DEPTH = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] st [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) st[i] <= '0;
    end else if (en_i) begin
      st[0] <= d_i;
      for (int i = 1; i < DEPTH; i++) st[i] <= st[i-1];
    end
  end

  assign q_o = st[DEPTH-1];
endmodule

// File: rtl/ldpc_cc_stage.sv
module ldpc_cc_stage #(
  parameter int M          = 128,
  parameter int PIPE_DEPTH = 11,
  parameter int LLR_W      = 6,
  localparam int PHW       = $clog2(M),
  localparam int BUS_W     = ldpc_stage_pkg::NUM_LINES * ldpc_stage_pkg::NUM_BITS * LLR_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [PHW-1:0]   phase_i,
  input  logic [BUS_W-1:0] llr_i,
  output logic             valid_o,
  output logic [BUS_W-1:0] llr_o
);
  import ldpc_stage_pkg::*;

  localparam int PW  = $clog2(M + 1);
  localparam int LAT = M + 1 + PIPE_DEPTH;

  logic signed [LLR_W-1:0] dl  [NUM_LINES][NUM_BITS][M+1];
  logic signed [LLR_W-1:0] upd [NUM_LINES][NUM_BITS][M+1];
  logic signed [LLR_W-1:0] chk_x [CHK_DEG];
  logic signed [LLR_W-1:0] chk_y [CHK_DEG];
  logic [PW-1:0]           ct;
  logic [PW-1:0]           it [NUM_INFO];
  logic [BUS_W-1:0]        exit_bus;

  always_comb begin
    ct = PW'(code_tap(int'(phase_i), M));
    for (int i = 0; i < NUM_INFO; i++) it[i] = PW'(info_tap(i, int'(phase_i), M));
  end

  // fixed code taps at both ends, phase taps in between; lines never collide
  assign chk_x[0] = dl[0][1][0];
  assign chk_x[1] = dl[1][1][ct];
  assign chk_x[2] = dl[2][1][M];
  for (genvar i = 0; i < NUM_INFO; i++) begin : g_itap
    assign chk_x[3+i] = dl[i][0][it[i]];
  end

  ldpc_check_node #(.LLR_W(LLR_W), .DEG(CHK_DEG)) u_chk (
    .x_i (chk_x),
    .y_o (chk_y)
  );

  always_comb begin
    upd = dl;
    upd[0][1][0]  = chk_y[0];
    upd[1][1][ct] = chk_y[1];
    upd[2][1][M]  = chk_y[2];
    for (int i = 0; i < NUM_INFO; i++) upd[i][0][it[i]] = chk_y[3+i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int l = 0; l < NUM_LINES; l++)
        for (int b = 0; b < NUM_BITS; b++)
          for (int p = 0; p <= M; p++) dl[l][b][p] <= '0;
    end else if (valid_i) begin
      for (int l = 0; l < NUM_LINES; l++)
        for (int b = 0; b < NUM_BITS; b++) begin
          dl[l][b][0] <= llr_i[(b*NUM_LINES+l)*LLR_W +: LLR_W];
          for (int p = 1; p <= M; p++) dl[l][b][p] <= upd[l][b][p-1];
        end
    end
  end

  for (genvar b = 0; b < NUM_BITS; b++) begin : g_vn
    logic signed [LLR_W-1:0] vn_in  [3];
    logic signed [LLR_W-1:0] vn_out [3];
    for (genvar l = 0; l < 3; l++) begin : g_ln
      assign vn_in[l] = upd[l][b][M];
      assign exit_bus[(b*NUM_LINES+l)*LLR_W +: LLR_W] = vn_out[l];
    end
    assign exit_bus[(b*NUM_LINES+3)*LLR_W +: LLR_W] = upd[3][b][M];

    ldpc_var_node #(.LLR_W(LLR_W)) u_vn (
      .ch_i  (upd[3][b][M]),
      .msg_i (vn_in),
      .msg_o (vn_out)
    );
  end

  ldpc_out_pipe #(.WIDTH(BUS_W), .DEPTH(LAT - M)) u_pipe (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (valid_i),
    .d_i    (exit_bus),
    .q_o    (llr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_o <= 1'b0;
    else         valid_o <= valid_i;
  end

  assert_phase_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> (int'(phase_i) < M));

  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(llr_o));

  assert_writeback_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (dl[0][1][1] == $past(chk_y[0])));

  assert_valid_out_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
endmodule

// File: tb/ldpc_cc_stage_tb_top.sv
module ldpc_cc_stage_tb_top;
  localparam int M  = 128;
  localparam int P  = 11;
  localparam int W  = 6;
  localparam int NF = 8;
  localparam int N  = M + 1 + P;
  localparam int PHW = $clog2(M);

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic valid_i = 1'b0;
  logic [PHW-1:0] phase_i = '0;
  logic [NF*W-1:0] llr_i = '0;
  logic valid_o;
  logic [NF*W-1:0] llr_o;

  always #4 clk = ~clk;

  ldpc_cc_stage #(.M(M), .PIPE_DEPTH(P), .LLR_W(W)) dut_i (
    .clk_i (clk), .rst_ni (rst_ni), .valid_i (valid_i), .phase_i (phase_i),
    .llr_i (llr_i), .valid_o (valid_o), .llr_o (llr_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  int md [4][2][M+1];
  int mpipe [P+1][NF];
  int ph = 0;
  bit last_v = 0;
  bit done = 0;

  function automatic int sat31(input int v);
    if (v > 31) return 31;
    if (v < -31) return -31;
    return v;
  endfunction

  function automatic int get_f(input int f);
    return int'($signed(llr_o[f*W +: W]));
  endfunction

  task automatic model_clear();
    for (int l = 0; l < 4; l++)
      for (int b = 0; b < 2; b++)
        for (int p = 0; p <= M; p++) md[l][b][p] = 0;
    for (int s = 0; s <= P; s++)
      for (int f = 0; f < NF; f++) mpipe[s][f] = 0;
    ph = 0;
  endtask

  task automatic model_step(input int fin [NF]);
    int tl [6];
    int tbt [6];
    int tp [6];
    int x [6];
    int y [6];
    int ex [NF];
    tl  = '{0, 1, 2, 0, 1, 2};
    tbt = '{1, 1, 1, 0, 0, 0};
    tp[0] = 0;
    tp[1] = 1 + ((5 * ph + 3) % (M - 1));
    tp[2] = M;
    for (int i = 0; i < 3; i++) tp[3+i] = 1 + (((2 * i + 3) * ph + 7 * i + 1) % (M - 1));
    for (int k = 0; k < 6; k++) x[k] = md[tl[k]][tbt[k]][tp[k]];
    for (int k = 0; k < 6; k++) begin
      int mn;
      bit ng;
      mn = 31;
      ng = 0;
      for (int n = 0; n < 6; n++) begin
        if (n != k) begin
          int a;
          a = (x[n] < 0) ? -x[n] : x[n];
          if (a > 31) a = 31;
          if (a < mn) mn = a;
          if (x[n] < 0) ng = ~ng;
        end
      end
      y[k] = ng ? -mn : mn;
    end
    for (int k = 0; k < 6; k++) md[tl[k]][tbt[k]][tp[k]] = y[k];
    for (int b = 0; b < 2; b++) begin
      int ch;
      ch = md[3][b][M];
      for (int l = 0; l < 3; l++)
        ex[b*4+l] = sat31(ch + md[(l+1)%3][b][M] + md[(l+2)%3][b][M]);
      ex[b*4+3] = ch;
    end
    for (int s = P; s >= 1; s--) mpipe[s] = mpipe[s-1];
    mpipe[0] = ex;
    for (int l = 0; l < 4; l++)
      for (int b = 0; b < 2; b++) begin
        for (int p = M; p >= 1; p--) md[l][b][p] = md[l][b][p-1];
        md[l][b][0] = fin[b*4+l];
      end
  endtask

  task automatic step(input bit v, input int fin [NF]);
    @(negedge clk);
    valid_i = v;
    phase_i = v ? PHW'(ph) : PHW'($urandom_range(0, M - 1));
    for (int f = 0; f < NF; f++) llr_i[f*W +: W] = W'(fin[f]);
    @(posedge clk);
    #1;
    if (v) begin
      model_step(fin);
      ph = (ph + 1) % M;
    end
    last_v = v;
  endtask

  task automatic cmp(input string tag);
    bit bad;
    logic [NF*W-1:0] exp_bus;
    bad = 0;
    for (int f = 0; f < NF; f++) begin
      exp_bus[f*W +: W] = W'(mpipe[P][f]);
      if (get_f(f) != mpipe[P][f]) bad = 1;
    end
    n_chk++;
    if (bad || valid_o !== last_v) begin
      n_fail++;
      $display("FAIL %s: llr_o=%h valid_o=%0b expected llr_o=%h valid_o=%0b",
               tag, llr_o, valid_o, exp_bus, last_v);
    end
  endtask

  task automatic rand_fields(output int fo [NF]);
    for (int f = 0; f < NF; f++) fo[f] = int'($urandom_range(0, 63)) - 32;
  endtask

  task automatic do_reset();
    int z [NF];
    z = '{default: 0};
    @(negedge clk);
    rst_ni = 0;
    valid_i = 0;
    model_clear();
    last_v = 0;
    repeat (3) @(negedge clk);
    n_chk++;
    if (llr_o !== '0 || valid_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 reset state: llr_o=%h valid_o=%0b expected 0 0", llr_o, valid_o);
    end
    rst_ni = 1;
    llr_i = '0;
    for (int i = 0; i < 2; i++) step(0, z);
  endtask

  // R1: zero stream after reset stays zero
  task automatic t_zero_stream();
    int z [NF];
    z = '{default: 0};
    do_reset();
    for (int j = 0; j < 30; j++) step(1, z);
    n_chk++;
    if (llr_o !== '0 || valid_o !== 1'b1) begin
      n_fail++;
      $display("FAIL R1 zero stream: llr_o=%h valid_o=%0b expected 0 1", llr_o, valid_o);
    end
  endtask

  // R2: channel fields arrive exactly N strobes later
  task automatic t_latency();
    int mk [NF];
    int z [NF];
    z = '{default: 0};
    mk = '{default: 0};
    mk[3] = 17;
    mk[7] = -9;
    do_reset();
    step(1, mk);
    for (int j = 1; j <= N; j++) begin
      step(1, z);
      if (j == N - 1) begin
        n_chk++;
        if (get_f(3) != 0 || get_f(7) != 0) begin
          n_fail++;
          $display("FAIL R2 early at strobe %0d: ch=%0d,%0d expected 0,0", j, get_f(3), get_f(7));
        end
      end
      if (j == N) begin
        n_chk++;
        if (get_f(3) != 17 || get_f(7) != -9) begin
          n_fail++;
          $display("FAIL R2 latency: ch=%0d,%0d expected 17,-9", get_f(3), get_f(7));
        end
      end
    end
  endtask

  // R3 R4 R5 R6 R8: random stream against model, wraps phase several times
  task automatic t_random();
    int fr [NF];
    do_reset();
    for (int j = 0; j < 600; j++) begin
      rand_fields(fr);
      step(1, fr);
      cmp("R3/R4/R5/R6 random");
    end
  endtask

  // R6: saturated inputs, clamp and passthrough
  task automatic t_saturate();
    int fr [NF];
    do_reset();
    fr = '{default: 31};
    for (int j = 0; j < 300; j++) begin
      step(1, fr);
      cmp("R6 all +31");
    end
    fr = '{default: -32};
    for (int j = 0; j < 300; j++) begin
      step(1, fr);
      cmp("R6 all -32");
    end
    n_chk++;
    if (get_f(3) != -32 || get_f(7) != -32) begin
      n_fail++;
      $display("FAIL R6 channel passthrough: %0d,%0d expected -32,-32", get_f(3), get_f(7));
    end
    for (int f = 0; f < NF; f++) begin
      if (f != 3 && f != 7) begin
        n_chk++;
        if (get_f(f) < -31 || get_f(f) > 31) begin
          n_fail++;
          $display("FAIL R6 clamp field %0d: %0d expected within -31..31", f, get_f(f));
        end
      end
    end
  endtask

  // R7 R8: gaps in the strobe leave state and output untouched
  task automatic t_stall();
    int fr [NF];
    do_reset();
    for (int j = 0; j < 200; j++) begin
      rand_fields(fr);
      step(1, fr);
    end
    cmp("R7 before gap");
    for (int g = 0; g < 3; g++) begin
      for (int j = 0; j < 7; j++) begin
        rand_fields(fr);
        step(0, fr);
        cmp("R7/R8 gap hold");
      end
      for (int j = 0; j < 60; j++) begin
        rand_fields(fr);
        step(1, fr);
        cmp("R7 resume after gap");
      end
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      finish_run();
    end
  end

  initial begin
    model_clear();
    t_zero_stream();
    t_latency();
    t_random();
    t_saturate();
    t_stall();
    done = 1;
    finish_run();
  end
endmodule